// File: doc/BRIEF.md
# Averaging ADC Conversion Sequencer

This block is the digital timing and data path of a successive-approximation converter. A single-cycle software start pulse launches one conversion. The block divides the bus clock into a conversion-clock enable and counts every phase in conversion-clock cycles. It runs a fixed 8-cycle startup phase. It then repeats a sample phase and a base conversion phase once for each sample to be averaged. At the end of every base phase it takes one code from a digital sample input, which stands in for the analog comparator array. The codes are summed. Their mean is returned right-justified to the chosen resolution, with a one-cycle done pulse.

Four configuration inputs are taken at the start pulse: divider, resolution, long-sample adder and averaging count. Software picks them to suit the source impedance and the output rate it needs. The state machine has five states. ST_IDLE waits for a start. ST_STARTUP counts the fixed adder. ST_SAMPLE counts the long-sample adder. ST_CONVERT counts the base time and captures a code on its last cycle. ST_FINISH forms the mean. The transitions are:

- ST_IDLE to ST_STARTUP on an accepted start.
- ST_STARTUP to ST_SAMPLE when the startup count expires.
- ST_SAMPLE to ST_CONVERT when the sample count expires.
- ST_CONVERT back to ST_SAMPLE while more samples remain.
- ST_CONVERT to ST_FINISH after the last sample.
- ST_FINISH to ST_IDLE unconditionally.

Top module: `adc_seq_avg`

## Requirements
- R1: div_sel_i picks the conversion-clock divide ratio: 0→1, 1→2, 2→4, 3→8, 4 to 7→16. All logic runs on clk, and the divider only produces an enable.
- R2: Let D be the divide ratio, N the averaging count, B the base time and L the long-sample adder. Call the clk edge that samples start_i high in idle the capture edge. done_o goes high exactly (8 + N×(B+L))×D + 1 clk cycles after the capture edge.
- R3: res_sel_i picks the resolution and base time: 0→8-bit with 17 cycles, 1→10-bit with 21 cycles, 2 or 3→12-bit with 25 cycles.
- R4: lst_sel_i picks the long-sample adder: 0→3 cycles, 1→13 cycles, 2 or 3→25 cycles.
- R5: avg_sel_i picks the averaging count: 0→1, 1→4, 2 or 3→32. result_o is the floor of the sum of the captured codes divided by that count. The accumulator never overflows.
- R6: Sample j (j = 1..N) is taken from sample_i at the clk edge (8 + j×(B+L))×D after the capture edge. Only its low 8, 10 or 12 bits are used. result_o is right-justified, and bits above the resolution are zero.
- R7: The configuration inputs are latched on the capture edge. Changing them while busy_o is high has no effect on timing or result.
- R8: A start_i pulse while busy_o is high is ignored. The conversion in progress keeps its length and result.
- R9: busy_o is high from the capture edge until done_o rises. done_o is high for exactly one cycle, and busy_o is low in that cycle. result_o holds its value until the next done.
- R10: During and after reset, busy_o, done_o and result_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Software start pulse |
| div_sel_i | input | 3 | Conversion-clock divide select |
| res_sel_i | input | 2 | Resolution select |
| lst_sel_i | input | 2 | Long-sample adder select |
| avg_sel_i | input | 2 | Averaging count select |
| sample_i | input | 12 | Digital stand-in for the converter code |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | 12 | Averaged, right-justified result |

## Verification
The bench builds the block with its default parameters: an 8-cycle startup adder, a 12-bit sample path and a divider reaching 16. Every divide ratio, every resolution, every long-sample choice and all three averaging counts are therefore reachable. This includes the longest case, 32 samples of 12 bits each at divide 16, which also fills the accumulator closest to its limit. Varying sample patterns check that captures land on the edges R6 predicts and that the mean truncates. Disturbed runs change the configuration inputs and pulse start mid-conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SAMPLE_W  = 12;
    localparam int MAX_SHIFT = 5;
    localparam int ACC_W     = SAMPLE_W + MAX_SHIFT;
    localparam int PHASE_W   = 5;
    localparam int REM_W     = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STARTUP,
        ST_SAMPLE,
        ST_CONVERT,
        ST_FINISH
    } seq_state_t;

    typedef struct packed {
        logic [2:0] div_sel;
        logic [1:0] res_sel;
        logic [1:0] lst_sel;
        logic [1:0] avg_sel;
    } seq_cfg_t;

    function automatic logic [PHASE_W-1:0] base_cycles(input logic [1:0] sel);
        case (sel)
            2'd0:    base_cycles = PHASE_W'(17);
            2'd1:    base_cycles = PHASE_W'(21);
            default: base_cycles = PHASE_W'(25);
        endcase
    endfunction

    function automatic logic [PHASE_W-1:0] lst_cycles(input logic [1:0] sel);
        case (sel)
            2'd0:    lst_cycles = PHASE_W'(3);
            2'd1:    lst_cycles = PHASE_W'(13);
            default: lst_cycles = PHASE_W'(25);
        endcase
    endfunction

    function automatic logic [REM_W-1:0] avg_count(input logic [1:0] sel);
        case (sel)
            2'd0:    avg_count = REM_W'(1);
            2'd1:    avg_count = REM_W'(4);
            default: avg_count = REM_W'(32);
        endcase
    endfunction

    function automatic logic [2:0] avg_shift(input logic [1:0] sel);
        case (sel)
            2'd0:    avg_shift = 3'd0;
            2'd1:    avg_shift = 3'd2;
            default: avg_shift = 3'd5;
        endcase
    endfunction

    function automatic logic [SAMPLE_W-1:0] res_mask(input logic [1:0] sel);
        case (sel)
            2'd0:    res_mask = SAMPLE_W'(12'h0FF);
            2'd1:    res_mask = SAMPLE_W'(12'h3FF);
            default: res_mask = SAMPLE_W'(12'hFFF);
        endcase
    endfunction

    function automatic logic [2:0] div_log(input logic [2:0] sel);
        div_log = (sel > 3'd4) ? 3'd4 : sel;
    endfunction

endpackage

// File: rtl/adc_clk_en.sv
module adc_clk_en #(
    parameter int MAX_LOG = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic [2:0] div_log_i,
    output logic       tick_o
);
    localparam int CNT_W = (MAX_LOG > 0) ? MAX_LOG : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;

    always_comb begin
        span   = (CNT_W+1)'(1) << div_log_i;
        tick_o = (cnt_q == CNT_W'(span - (CNT_W+1)'(1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (clear_i || tick_o) cnt_q <= '0;
        else                        cnt_q <= cnt_q + CNT_W'(1);
    end

    // R1: above divide-by-1 an enable is never two cycles in a row
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !clear_i && div_log_i != 3'd0 && $stable(div_log_i)) |=> !tick_o);

endmodule

// File: rtl/adc_accum.sv
module adc_accum
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                add_i,
    input  logic [SAMPLE_W-1:0] code_i,
    output logic [ACC_W-1:0]    acc_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_o <= '0;
        else if (clear_i) acc_o <= '0;
        else if (add_i)   acc_o <= acc_o + ACC_W'(code_i);
    end

    // R5: summing never wraps the accumulator
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (add_i && !clear_i) |=> (acc_o >= $past(acc_o)));

endmodule

// File: rtl/adc_seq_avg.sv
module adc_seq_avg
    import adc_seq_pkg::*;
#(
    parameter int STARTUP_CYC = 8,
    parameter int MAX_DIV_LOG = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [2:0]          div_sel_i,
    input  logic [1:0]          res_sel_i,
    input  logic [1:0]          lst_sel_i,
    input  logic [1:0]          avg_sel_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [SAMPLE_W-1:0] result_o
);
    seq_state_t          state_q, state_d;
    seq_cfg_t            cfg_q, cfg_d;
    logic [PHASE_W-1:0]  phase_q, phase_d;
    logic [REM_W-1:0]    rem_q, rem_d;
    logic                tick, last_tick, accept, add_en;
    logic [ACC_W-1:0]    acc;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign last_tick = tick && (phase_q == PHASE_W'(1));

    adc_clk_en #(.MAX_LOG(MAX_DIV_LOG)) i_clk_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .div_log_i (div_log(cfg_q.div_sel)),
        .tick_o    (tick)
    );

    adc_accum i_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .add_i   (add_en),
        .code_i  (sample_i & res_mask(cfg_q.res_sel)),
        .acc_o   (acc)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        cfg_d   = cfg_q;
        phase_d = phase_q;
        rem_d   = rem_q;
        add_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_STARTUP;
                    cfg_d   = '{div_sel: div_sel_i, res_sel: res_sel_i,
                                lst_sel: lst_sel_i, avg_sel: avg_sel_i};
                    phase_d = PHASE_W'(STARTUP_CYC);
                    rem_d   = avg_count(avg_sel_i);
                end
            end
            ST_STARTUP: begin
                if (last_tick) begin
                    state_d = ST_SAMPLE;
                    phase_d = lst_cycles(cfg_q.lst_sel);
                end else if (tick) begin
                    phase_d = phase_q - PHASE_W'(1);
                end
            end
            ST_SAMPLE: begin
                if (last_tick) begin
                    state_d = ST_CONVERT;
                    phase_d = base_cycles(cfg_q.res_sel);
                end else if (tick) begin
                    phase_d = phase_q - PHASE_W'(1);
                end
            end
            ST_CONVERT: begin
                if (last_tick) begin
                    add_en = 1'b1;
                    if (rem_q == REM_W'(1)) begin
                        state_d = ST_FINISH;
                    end else begin
                        state_d = ST_SAMPLE;
                        phase_d = lst_cycles(cfg_q.lst_sel);
                        rem_d   = rem_q - REM_W'(1);
                    end
                end else if (tick) begin
                    phase_d = phase_q - PHASE_W'(1);
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            phase_q <= '0;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_d;
            phase_q <= phase_d;
            rem_q   <= rem_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            result_o <= '0;
        end else begin
            done_o <= (state_q == ST_FINISH);
            if (state_q == ST_FINISH)
                result_o <= SAMPLE_W'(acc >> avg_shift(cfg_q.avg_sel));
        end
    end

    assign busy_o = (state_q != ST_IDLE);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    assert_busy_ends_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    assert_cfg_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(cfg_q));
    assert_phase_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q != ST_FINISH) |-> (phase_q != '0));
    assert_rem_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE || state_q == ST_CONVERT) |-> (rem_q != '0));

endmodule

// File: tb/test_adc_seq_avg.sv
module test_adc_seq_avg;

    typedef struct packed {
        logic [2:0]  dv;
        logic [1:0]  rs;
        logic [1:0]  ls;
        logic [1:0]  av;
        logic [11:0] smp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 2'd0, 2'd0, 12'hFA5},
        '{3'd0, 2'd0, 2'd0, 2'd1, 12'h13C},
        '{3'd0, 2'd0, 2'd0, 2'd2, 12'h07E},
        '{3'd1, 2'd1, 2'd1, 2'd0, 12'hFFF},
        '{3'd2, 2'd2, 2'd2, 2'd1, 12'hABC},
        '{3'd3, 2'd3, 2'd3, 2'd0, 12'h801},
        '{3'd4, 2'd1, 2'd2, 2'd1, 12'h6D2},
        '{3'd7, 2'd2, 2'd1, 2'd2, 12'hFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  div_sel_i = '0;
    logic [1:0]  res_sel_i = '0;
    logic [1:0]  lst_sel_i = '0;
    logic [1:0]  avg_sel_i = '0;
    logic [11:0] sample_i = '0;
    logic        busy_o, done_o;
    logic [11:0] result_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    adc_seq_avg i_adc_seq_avg (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .div_sel_i(div_sel_i), .res_sel_i(res_sel_i),
        .lst_sel_i(lst_sel_i), .avg_sel_i(avg_sel_i),
        .sample_i(sample_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o)
    );

    function automatic int f_div(input logic [2:0] s);
        return (s >= 3'd4) ? 16 : (1 << s);
    endfunction
    function automatic int f_base(input logic [1:0] s);
        return (s == 2'd0) ? 17 : (s == 2'd1) ? 21 : 25;
    endfunction
    function automatic int f_lst(input logic [1:0] s);
        return (s == 2'd0) ? 3 : (s == 2'd1) ? 13 : 25;
    endfunction
    function automatic int f_avg(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : 32;
    endfunction
    function automatic int f_mask(input logic [1:0] s);
        return (s == 2'd0) ? 'hFF : (s == 2'd1) ? 'h3FF : 'hFFF;
    endfunction
    function automatic logic [11:0] f_g(input bit vary, input logic [11:0] smp, input int e);
        return vary ? 12'((e * 37 + 'h5A3) & 'hFFF) : smp;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one conversion; vary: sample changes each cycle; disturb: start and config change mid-run
    task automatic run_conv(input vec_t v, input bit vary, input bit disturb);
        int d, p, n, tot, e, sum, k;
        bit busy_ok;
        d = f_div(v.dv);
        p = f_base(v.rs) + f_lst(v.ls);
        n = f_avg(v.av);
        tot = (8 + n * p) * d;
        sum = 0;
        busy_ok = 1'b1;
        e = -1;
        @(negedge clk);
        div_sel_i = v.dv; res_sel_i = v.rs; lst_sel_i = v.ls; avg_sel_i = v.av;
        sample_i = f_g(vary, v.smp, 0);
        start_i = 1'b1;
        while (e < 40000) begin
            @(posedge clk);
            e++;
            if (e > 0 && (e % d) == 0) begin
                k = e / d - 8;
                if (k > 0 && (k % p) == 0 && (k / p) <= n)
                    sum += int'(f_g(vary, v.smp, e)) & f_mask(v.rs);
            end
            @(negedge clk);
            start_i = 1'b0;
            if (disturb && e == 5) begin
                start_i = 1'b1;
                div_sel_i = ~v.dv; res_sel_i = ~v.rs; lst_sel_i = ~v.ls; avg_sel_i = ~v.av;
            end
            sample_i = f_g(vary, v.smp, e + 1);
            if (done_o) break;
            if (!busy_o) busy_ok = 1'b0;
        end
        chk(e == tot + 1, "R2 latency", e, tot + 1);
        chk(int'(result_o) == sum / n, "R5/R6 result", int'(result_o), sum / n);
        chk(busy_ok && !busy_o, "R9 busy span", int'(busy_o), 0);
        if (disturb) chk(e == tot + 1, "R7/R8 ignored mid-run", e, tot + 1);
        @(negedge clk);
        chk(!done_o, "R9 done one cycle", int'(done_o), 0);
        repeat (3) @(negedge clk);
        chk(int'(result_o) == sum / n, "R9 result held", int'(result_o), sum / n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!busy_o && !done_o && result_o == '0, "R10 reset",
            int'({busy_o, done_o}) + int'(result_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && result_o == '0, "R10 after reset",
            int'({busy_o, done_o}) + int'(result_o), 0);

        // vector table: R1 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) run_conv(VECS[i], 1'b0, 1'b0);

        // R6: capture edges and truncation with varying codes
        run_conv('{3'd0, 2'd2, 2'd0, 2'd1, 12'h000}, 1'b1, 1'b0);
        run_conv('{3'd1, 2'd0, 2'd1, 2'd1, 12'h000}, 1'b1, 1'b0);
        run_conv('{3'd0, 2'd1, 2'd2, 2'd2, 12'h000}, 1'b1, 1'b0);

        // R7 R8: start pulse and config change while busy
        run_conv('{3'd1, 2'd0, 2'd0, 2'd1, 12'h0C3}, 1'b0, 1'b1);
        run_conv('{3'd0, 2'd2, 2'd1, 2'd0, 12'h000}, 1'b1, 1'b1);

        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule